// File: doc/BRIEF.md
# Security-Gated Sticky Lock Register Bank

This block holds two small banks of lock bits on a simple 32-bit register bus. One bank guards configuration that belongs to the secure world: the secure vector-table base and interrupt-priority setup, the secure memory-protection registers and the security-attribution registers. The other bank guards the non-secure vector-table base and the non-secure memory-protection control, region-number and region-base registers. Software sets a lock bit by writing 1 to it. After that the bit stays set, and only a system reset clears it. Each lock bit drives a write-inhibit output that the guarded register group uses to refuse writes.

The block filters every bus access on four things: the global security-enable input, the secure or non-secure attribute of the access, the privilege level and the access size. An access that fails the filter reads as zero and changes nothing. A non-secure word access to the secure bank while security is enabled also raises a one-cycle illegal-access pulse, so the system can log or trap it.

Bus requests are taken in the cycle `req_valid_i` is high. The read data is registered and shows up in the next cycle. The illegal-access pulse is combinational, in the cycle of the request. The inhibit outputs are the lock flops themselves.

Top module: `seclock_regs`

## Requirements
- R1: After reset both banks hold zero, every inhibit output is low, `rdata_o` is zero and `illegal_o` is low.
- R2: A permitted write to the secure bank (byte address 0x50) ORs wdata bits 2:0 into the lock bits. Bit 0 drives `s_inhibit_o[0]` (vector table and priority), bit 1 drives `s_inhibit_o[1]` (memory protection) and bit 2 drives `s_inhibit_o[2]` (attribution unit). The inhibit is high from the cycle after the write.
- R3: A written 0 never clears a lock bit. Only reset clears one.
- R4: A permitted read returns the bank's lock bits, zero-extended to 32 bits, in the cycle after the request. Reserved bits read as zero, and writes to them are ignored.
- R5: While `sec_en_i` is low, the secure bank reads as zero, ignores all writes and raises no event.
- R6: While `sec_en_i` is high, a non-secure (`secure_i`=0) access to the secure bank reads as zero and its write is ignored. A word-sized access of this kind, read or write and of any privilege, pulses `illegal_o` high in its own request cycle.
- R7: An unprivileged (`priv_i`=0) access to either bank reads as zero and its write is ignored.
- R8: An access whose `size_i` is not word (encoding 0 = byte, 1 = halfword, 2 = word) reads as zero, its write is ignored and it raises no event.
- R9: The non-secure bank sits at byte address 0x4C. It accepts any privileged word access of either security attribute, whatever the state of `sec_en_i`. Bit 0 drives `ns_inhibit_o[0]` (vector table) and bit 1 drives `ns_inhibit_o[1]` (memory protection).
- R10: An access to any other address reads as zero, changes no lock bit and raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset |
| sec_en_i | input | 1 | Global security enable |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| secure_i | input | 1 | Access carries the secure attribute |
| priv_i | input | 1 | Access is privileged |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| illegal_o | output | 1 | Illegal-access event pulse |
| s_inhibit_o | output | 3 | Write inhibits for the secure groups |
| ns_inhibit_o | output | 2 | Write inhibits for the non-secure groups |

## Verification
A lock bit that is wrong in either direction shows at an inhibit output one cycle after the access that corrupted it, and at `rdata_o` one cycle after the next read. A bad filter decision shows up in different ways. A set bit that should have been ignored shows up right away. A bit that falls without a reset shows up as soon as a later read or the inhibit port is sampled. A missing or spurious event shows in the request cycle itself. The bench therefore samples every output on every vector, so that none of these faults can hide behind a later access.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Per-cycle decision of the access filter
    typedef struct packed {
        logic s_wr;     // permitted write to the secure bank
        logic s_rd;     // permitted read of the secure bank
        logic ns_wr;    // permitted write to the non-secure bank
        logic ns_rd;    // permitted read of the non-secure bank
        logic illegal;  // event pulse
    } acc_dec_t;

endpackage

// File: rtl/seclock_filter.sv
module seclock_filter
    import seclock_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] S_OFFSET  = 'h50,
    parameter logic [ADDR_W-1:0] NS_OFFSET = 'h4C
) (
    input  logic              valid_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              secure_i,
    input  logic              priv_i,
    input  logic              sec_en_i,
    output acc_dec_t          dec_o
);

    logic hit_s, hit_ns, word, s_ok, ns_ok;

    always_comb begin
        hit_s  = valid_i && (addr_i == S_OFFSET);
        hit_ns = valid_i && (addr_i == NS_OFFSET);
        word   = (acc_size_e'(size_i) == SZ_WORD);

        // secure bank: security on, secure attribute, privileged, word
        s_ok   = hit_s && sec_en_i && secure_i && priv_i && word;
        // non-secure bank: privileged word access from either world
        ns_ok  = hit_ns && priv_i && word;

        dec_o.s_wr    = s_ok && we_i;
        dec_o.s_rd    = s_ok && !we_i;
        dec_o.ns_wr   = ns_ok && we_i;
        dec_o.ns_rd   = ns_ok && !we_i;
        dec_o.illegal = hit_s && sec_en_i && !secure_i && word;
    end

endmodule

// File: rtl/seclock_bank.sv
module seclock_bank #(
    parameter int NBITS  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_en_i,
    input  logic [DATA_W-1:0] set_data_i,
    output logic [NBITS-1:0]  lock_o
);

    typedef struct packed {
        logic [NBITS-1:0] lock;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NBITS; i++) begin
            // bits only ever rise; reserved data bits are never looked at
            st_d.lock[i] = st_q.lock[i] | (set_en_i & set_data_i[i]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lock_o = st_q.lock;

endmodule

// File: rtl/seclock_regs.sv
module seclock_regs
    import seclock_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int S_BITS  = 3,
    parameter int NS_BITS = 2,
    parameter logic [ADDR_W-1:0] S_OFFSET = 'h50
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sec_en_i,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              secure_i,
    input  logic              priv_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              illegal_o,
    output logic [S_BITS-1:0] s_inhibit_o,
    output logic [NS_BITS-1:0] ns_inhibit_o
);

    localparam logic [ADDR_W-1:0] NS_OFFSET = S_OFFSET - ADDR_W'(4);

    acc_dec_t dec;
    logic [S_BITS-1:0]  s_lock;
    logic [NS_BITS-1:0] ns_lock;

    seclock_filter #(
        .ADDR_W   (ADDR_W),
        .S_OFFSET (S_OFFSET),
        .NS_OFFSET(NS_OFFSET)
    ) u_filter (
        .valid_i (req_valid_i),
        .we_i    (req_we_i),
        .addr_i  (addr_i),
        .size_i  (size_i),
        .secure_i(secure_i),
        .priv_i  (priv_i),
        .sec_en_i(sec_en_i),
        .dec_o   (dec)
    );

    seclock_bank #(.NBITS(S_BITS), .DATA_W(DATA_W)) u_s_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_en_i  (dec.s_wr),
        .set_data_i(wdata_i),
        .lock_o    (s_lock)
    );

    seclock_bank #(.NBITS(NS_BITS), .DATA_W(DATA_W)) u_ns_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_en_i  (dec.ns_wr),
        .set_data_i(wdata_i),
        .lock_o    (ns_lock)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (req_valid_i) begin
            // every accepted request refreshes the read register; denied reads give zero
            if (dec.s_rd)
                rd_d.rdata = {{(DATA_W-S_BITS){1'b0}}, s_lock};
            else if (dec.ns_rd)
                rd_d.rdata = {{(DATA_W-NS_BITS){1'b0}}, ns_lock};
            else
                rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata_o      = rd_q.rdata;
    assign illegal_o    = dec.illegal;
    assign s_inhibit_o  = s_lock;
    assign ns_inhibit_o = ns_lock;

endmodule

// File: rtl/seclock_regs_chk.sv
module seclock_regs_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int S_BITS  = 3,
    parameter int NS_BITS = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sec_en_i,
    input logic               req_valid_i,
    input logic               req_we_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [1:0]         size_i,
    input logic               secure_i,
    input logic               priv_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               illegal_o,
    input logic [S_BITS-1:0]  s_inhibit_o,
    input logic [NS_BITS-1:0] ns_inhibit_o
);

    // R3
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(s_inhibit_o) & ~s_inhibit_o) == '0) &&
        (($past(ns_inhibit_o) & ~ns_inhibit_o) == '0));

    // R6
    event_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (req_valid_i && sec_en_i && !secure_i && size_i == 2'd2));

    // R5
    disabled_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !sec_en_i && !illegal_o && addr_i != 'h4C) |=> $stable(s_inhibit_o));

    // R7
    unpriv_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !priv_i) |=> ($stable(s_inhibit_o) && $stable(ns_inhibit_o)));

    // R7
    unpriv_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_we_i && !priv_i) |=> (rdata_o == '0));

    // R8
    narrow_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && size_i != 2'd2) |=>
            ($stable(s_inhibit_o) && $stable(ns_inhibit_o) && rdata_o == '0));

endmodule

bind seclock_regs seclock_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .S_BITS (S_BITS),
    .NS_BITS(NS_BITS)
) u_chk (.*);

// File: tb/seclock_regs_tb.sv
module seclock_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_en = 1'b0;
    logic        valid = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = '0;
    logic        secure = 1'b0;
    logic        priv = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        illegal;
    logic [2:0]  s_inh;
    logic [1:0]  ns_inh;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seclock_regs u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sec_en_i    (sec_en),
        .req_valid_i (valid),
        .req_we_i    (we),
        .addr_i      (addr),
        .size_i      (size),
        .secure_i    (secure),
        .priv_i      (priv),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .illegal_o   (illegal),
        .s_inhibit_o (s_inh),
        .ns_inhibit_o(ns_inh)
    );

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Vector layout: req[87:84] we[83] addr[82:75] wdata[74:43] size[42:41]
    // sec[40] priv[39] en[38] exp_rd[37:6] exp_ill[5] exp_s[4:2] exp_ns[1:0]
    localparam int NV = 18;
    localparam logic [87:0] VEC [NV] = '{
        // R1 secure read after reset
        {4'd1, 1'b0, 8'h50, 32'h0,        2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b000, 2'b00},
        // R7 unprivileged write
        {4'd7, 1'b1, 8'h50, 32'h7,        2'd2, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, 3'b000, 2'b00},
        // R8 byte write
        {4'd8, 1'b1, 8'h50, 32'h7,        2'd0, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b000, 2'b00},
        // R6 non-secure write raises event
        {4'd6, 1'b1, 8'h50, 32'h7,        2'd2, 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 3'b000, 2'b00},
        // R6 non-secure read raises event
        {4'd6, 1'b0, 8'h50, 32'h0,        2'd2, 1'b0, 1'b1, 1'b1, 32'h0, 1'b1, 3'b000, 2'b00},
        // R5 security disabled write
        {4'd5, 1'b1, 8'h50, 32'h7,        2'd2, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 3'b000, 2'b00},
        // R2 set bit 1 only, reserved bits ignored
        {4'd2, 1'b1, 8'h50, 32'hFFFFFFFA, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b010, 2'b00},
        // R4 readback
        {4'd4, 1'b0, 8'h50, 32'h0,        2'd2, 1'b1, 1'b1, 1'b1, 32'h2, 1'b0, 3'b010, 2'b00},
        // R3 writing zero keeps lock
        {4'd3, 1'b1, 8'h50, 32'h0,        2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b010, 2'b00},
        // R2 set bits 0 and 2
        {4'd2, 1'b1, 8'h50, 32'h5,        2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b111, 2'b00},
        // R5 read with security disabled
        {4'd5, 1'b0, 8'h50, 32'h0,        2'd2, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 3'b111, 2'b00},
        // R9 non-secure write to non-secure bank
        {4'd9, 1'b1, 8'h4C, 32'h1,        2'd2, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0, 3'b111, 2'b01},
        // R9 secure read of non-secure bank
        {4'd9, 1'b0, 8'h4C, 32'h0,        2'd2, 1'b1, 1'b1, 1'b1, 32'h1, 1'b0, 3'b111, 2'b01},
        // R7 unprivileged write to non-secure bank
        {4'd7, 1'b1, 8'h4C, 32'h2,        2'd2, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0, 3'b111, 2'b01},
        // R10 unmapped write
        {4'd10,1'b1, 8'h48, 32'h3,        2'd2, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b111, 2'b01},
        // R10 unmapped read
        {4'd10,1'b0, 8'h48, 32'h0,        2'd2, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0, 3'b111, 2'b01},
        // R8 halfword write to non-secure bank
        {4'd8, 1'b1, 8'h4C, 32'h2,        2'd1, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 3'b111, 2'b01},
        // R9 word write with security disabled still reaches non-secure bank
        {4'd9, 1'b1, 8'h4C, 32'h2,        2'd2, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 3'b111, 2'b11}
    };

    initial begin : watchdog
        #200us;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check(1, "rdata in reset", rdata, 32'h0);
        check(1, "s_inh in reset", {29'h0, s_inh}, 32'h0);
        check(1, "ns_inh in reset", {30'h0, ns_inh}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            valid  = 1'b1;
            we     = VEC[i][83];
            addr   = VEC[i][82:75];
            wdata  = VEC[i][74:43];
            size   = VEC[i][42:41];
            secure = VEC[i][40];
            priv   = VEC[i][39];
            sec_en = VEC[i][38];
            #1;
            check(int'(VEC[i][87:84]), $sformatf("vec %0d illegal", i), {31'h0, illegal}, {31'h0, VEC[i][5]});
            @(posedge clk);
            #1;
            check(int'(VEC[i][87:84]), $sformatf("vec %0d rdata", i), rdata, VEC[i][37:6]);
            check(int'(VEC[i][87:84]), $sformatf("vec %0d s_inh", i), {29'h0, s_inh}, {29'h0, VEC[i][4:2]});
            check(int'(VEC[i][87:84]), $sformatf("vec %0d ns_inh", i), {30'h0, ns_inh}, {30'h0, VEC[i][1:0]});
        end

        // R8 non-secure byte access to the secure bank raises no event
        @(negedge clk);
        we = 1'b0; addr = 8'h50; size = 2'd0; secure = 1'b0; priv = 1'b1; sec_en = 1'b1;
        #1;
        check(8, "narrow non-secure event", {31'h0, illegal}, 32'h0);
        @(negedge clk);
        valid = 1'b0;
        #1;
        // R6 no event without a request
        check(6, "idle event", {31'h0, illegal}, 32'h0);

        // R3 only reset clears the locks
        rst_n = 1'b0;
        #1;
        check(3, "s_inh after reset", {29'h0, s_inh}, 32'h0);
        check(3, "ns_inh after reset", {30'h0, ns_inh}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        valid = 1'b1; we = 1'b0; addr = 8'h4C; size = 2'd2; secure = 1'b1; priv = 1'b1;
        @(posedge clk);
        #1;
        // R4 readback after reset
        check(4, "ns read after reset", rdata, 32'h0);
        @(negedge clk);
        valid = 1'b0;

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule